// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Sequencer

This block is a synchronous controller for an asynchronous DRAM whose strobes are all active low. It holds 2^(ROW_W+COL_W) words of DATA_W bits; the default is 256K by 8, with 9 row bits and 9 column bits. A client issues one read or one write at a time over a valid/ready handshake. Each request carries a flat word address, write data and a per-request timing flavour, which is either early or late. The controller splits the address into a row part and a column part. It places them one after the other on a single shared address bus and orders the row strobe, column strobe, write enable and output enable so that the DRAM latches each part in turn.

The bidirectional data pins appear as three separate signals: an output data bus, a drive enable and an input data bus. Read data is sampled in the last cycle that the column strobe is low. It is handed back with a one-cycle valid pulse.

A free-running timer raises a refresh request every RFSH_INTERVAL clock cycles. The refresh is a row-strobe-only cycle driven from a wrapping row counter. It runs as soon as any access in progress has finished, and it goes ahead of waiting requests.

Minimum row precharge, row-to-column delay, column pulse width and total row cycle are parameters counted in clocks. The sequencer adds one address setup cycle in front of each strobe edge.

Top module: `dram_seq_ctrl`

## Requirements
- R1: Out of reset and whenever no cycle is in progress, all four strobes are high, the drive enable is low, the address bus reads zero, read-valid is low and `req_ready` is high unless a refresh is pending.
- R2: With ROW_HIGH=1 the row is the upper ROW_W address bits and the column is the lower COL_W bits. Each part is on the bus in the cycle before its strobe falls and stays there while that strobe is low.
- R3: The column strobe falls only while the row strobe is low, at least T_RCD cycles after the row strobe fell, and stays low for at least T_CAS cycles.
- R4: Before each fall, the row strobe has been high for at least T_RP cycles. Successive falls of the row strobe are at least T_RC cycles apart.
- R5: A write (`req_we`=1) drives `req_wdata` with the drive enable high and the output enable high. It lowers the write enable while the column strobe is low, so the word lands at the addressed location.
- R6: A read (`req_we`=0) keeps the write enable high and lowers the output enable. It returns the DRAM data seen in the last column-strobe-low cycle on `rd_data`, with `rd_valid` high for exactly the first cycle after the column strobe rises. A write never pulses `rd_valid`.
- R7: With `req_late`=0, the output enable (read) or write enable (write) is already low when the column strobe falls.
- R8: With `req_late`=1, that enable is still high when the column strobe falls and goes low while the column strobe is still low.
- R9: Refresh cycles lower the row strobe with the refresh counter on the bus and never lower the column strobe. The counter starts at zero and advances by one, modulo 2^ROW_W, per refresh.
- R10: A refresh request is raised every RFSH_INTERVAL cycles and blocks `req_ready`. It is served before any waiting request, so two refresh cycles never lie further apart than RFSH_INTERVAL plus one access time.
- R11: The drive enable is high only while the row strobe is low and the output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | 0 = early enable, 1 = late enable |
| req_addr | input | ROW_W+COL_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| dram_a | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data pins |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
A wrong state or counter in the sequencer shows up at the pins within one row cycle. The failure takes one of these forms:
- a strobe edge that comes too early against the parameters;
- a column strobe with no row strobe;
- an enable on the wrong side of the column-strobe fall;
- a word written to, or read from, the wrong row/column pair.

A broken refresh counter or broken refresh priority appears at the next refresh as a row out of sequence or as a gap that is too long. A faulty capture point appears on the same read as a wrong `rd_data` value or a missing `rd_valid` pulse.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RAS  = 2'd1,
      ST_CAS  = 2'd2,
      ST_PRE  = 2'd3
   } seq_st_t;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
   parameter int ROW_W    = 9,
   parameter int COL_W    = 9,
   parameter int ROW_HIGH = 1
) (
   input  logic [ROW_W+COL_W-1:0] addr,
   output logic [ROW_W-1:0]       row,
   output logic [COL_W-1:0]       col
);
   localparam int ADDR_W = ROW_W + COL_W;

   if (ROW_HIGH != 0) begin : g_row_high
      assign row = addr[ADDR_W-1:COL_W];
      assign col = addr[COL_W-1:0];
   end else begin : g_row_low
      assign row = addr[ROW_W-1:0];
      assign col = addr[ADDR_W-1:ROW_W];
   end
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched #(
   parameter int ROW_W         = 9,
   parameter int RFSH_INTERVAL = 390
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   output logic             pend,
   output logic [ROW_W-1:0] row
);
   localparam int IW = $clog2(RFSH_INTERVAL);

   if (RFSH_INTERVAL < 2) begin : g_bad_interval
      $error("RFSH_INTERVAL must be at least 2");
   end

   logic [IW-1:0] tmr;
   logic          tick;

   assign tick = (tmr == IW'(RFSH_INTERVAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr  <= '0;
         pend <= 1'b0;
         row  <= '0;
      end else begin
         tmr  <= tick ? '0 : tmr + 1'b1;
         pend <= tick | (pend & ~ack);
         if (ack) row <= row + 1'b1;
      end
   end

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ack) |-> (row == ROW_W'($past(row) + 1'b1)));  // R9
   AST_ACK_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> pend);  // R10
endmodule

// File: rtl/dram_strobe_dec.sv
module dram_strobe_dec
   import dram_seq_pkg::*;
#(
   parameter int A_W   = 9,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_st_t          st,
   input  logic [CNT_W-1:0] cnt,
   input  logic             is_wr,
   input  logic             late,
   input  logic [A_W-1:0]   row_bus,
   input  logic [A_W-1:0]   col_bus,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe,
   output logic [A_W-1:0]   a
);
   logic in_cas, cas_low, en_ok;

   assign in_cas  = (st == ST_CAS);
   assign cas_low = in_cas && (cnt != '0);
   // early: enable from the setup cycle; late: from the second CAS-low cycle
   assign en_ok   = !late || (cnt >= CNT_W'(2));

   always_comb begin
      ras_n = !((st == ST_RAS && cnt != '0) || in_cas);
      cas_n = !cas_low;
      we_n  = !(in_cas && is_wr && en_ok);
      oe_n  = !(in_cas && !is_wr && en_ok);
      dq_oe = in_cas && is_wr;
      case (st)
         ST_RAS:  a = row_bus;
         ST_CAS:  a = col_bus;
         default: a = '0;
      endcase
   end

   AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);  // R3
   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (oe_n && !ras_n));  // R11
   AST_ROW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $stable(a));  // R2
   AST_COL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> $stable(a));  // R2
   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n);  // R5
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dram_seq_pkg::*;
#(
   parameter int ROW_W         = 9,
   parameter int COL_W         = 9,
   parameter int DATA_W        = 8,
   parameter int T_RP          = 2,
   parameter int T_RCD         = 2,
   parameter int T_CAS         = 2,
   parameter int T_RC          = 9,
   parameter int RFSH_INTERVAL = 390,
   parameter int ROW_HIGH      = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_we,
   input  logic                   req_late,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
   output logic                   dram_ras_n,
   output logic                   dram_cas_n,
   output logic                   dram_we_n,
   output logic                   dram_oe_n,
   output logic [DATA_W-1:0]      dram_dq_out,
   output logic                   dram_dq_oe,
   input  logic [DATA_W-1:0]      dram_dq_in
);
   localparam int A_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int LOW_ACC = T_RCD + T_CAS + 1;
   localparam int PRE_LEN = (T_RP > T_RC - LOW_ACC) ? T_RP : (T_RC - LOW_ACC);
   localparam int MAXC    = (LOW_ACC > PRE_LEN) ? LOW_ACC : PRE_LEN;
   localparam int CNT_W   = $clog2(MAXC + 1);
   localparam int HW      = $clog2(T_RP + 1) + 1;

   if (T_CAS < 2)   begin : g_bad_cas  $error("T_CAS must be at least 2"); end
   if (T_RCD < 1)   begin : g_bad_rcd  $error("T_RCD must be at least 1"); end
   if (T_RP < 1)    begin : g_bad_rp   $error("T_RP must be at least 1");  end
   if (RFSH_INTERVAL < 2 * (LOW_ACC + PRE_LEN + 2)) begin : g_bad_rf
      $error("RFSH_INTERVAL too short for one access plus one refresh");
   end

   seq_st_t          st;
   logic [CNT_W-1:0] cnt;
   logic             is_rf, is_wr, late;
   logic [A_W-1:0]   lat_row, lat_col;
   logic [DATA_W-1:0] lat_wd;
   logic             rf_pend, rf_ack;
   logic [ROW_W-1:0] rf_row, sp_row;
   logic [COL_W-1:0] sp_col;

   dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .ROW_HIGH(ROW_HIGH)) u_split (
      .addr (req_addr),
      .row  (sp_row),
      .col  (sp_col)
   );

   dram_rfsh_sched #(.ROW_W(ROW_W), .RFSH_INTERVAL(RFSH_INTERVAL)) u_rfsh (
      .clk   (clk),
      .rst_n (rst_n),
      .ack   (rf_ack),
      .pend  (rf_pend),
      .row   (rf_row)
   );

   assign req_ready   = (st == ST_IDLE) && !rf_pend;
   assign rf_ack      = (st == ST_IDLE) && rf_pend;
   assign dram_dq_out = lat_wd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         is_rf    <= 1'b0;
         is_wr    <= 1'b0;
         late     <= 1'b0;
         lat_row  <= '0;
         lat_col  <= '0;
         lat_wd   <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (rf_pend) begin
                  st      <= ST_RAS;
                  is_rf   <= 1'b1;
                  is_wr   <= 1'b0;
                  lat_row <= A_W'(rf_row);
               end else if (req_valid) begin
                  st      <= ST_RAS;
                  is_rf   <= 1'b0;
                  is_wr   <= req_we;
                  late    <= req_late;
                  lat_row <= A_W'(sp_row);
                  lat_col <= A_W'(sp_col);
                  lat_wd  <= req_wdata;
               end
            end
            ST_RAS: begin
               if (!is_rf && cnt == CNT_W'(T_RCD)) begin
                  st  <= ST_CAS;
                  cnt <= '0;
               end else if (is_rf && cnt == CNT_W'(LOW_ACC)) begin
                  st  <= ST_PRE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CAS: begin
               if (cnt == CNT_W'(T_CAS)) begin
                  st  <= ST_PRE;
                  cnt <= '0;
                  if (!is_wr) begin
                     rd_data  <= dram_dq_in;
                     rd_valid <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == CNT_W'(PRE_LEN - 1)) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   dram_strobe_dec #(.A_W(A_W), .CNT_W(CNT_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st),
      .cnt     (cnt),
      .is_wr   (is_wr),
      .late    (late),
      .row_bus (lat_row),
      .col_bus (lat_col),
      .ras_n   (dram_ras_n),
      .cas_n   (dram_cas_n),
      .we_n    (dram_we_n),
      .oe_n    (dram_oe_n),
      .dq_oe   (dram_dq_oe),
      .a       (dram_a)
   );

   // checker state: consecutive cycles with the row strobe high, saturating
   logic [HW-1:0] ras_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ras_hi_cnt <= HW'(T_RP);
      else if (!dram_ras_n)                  ras_hi_cnt <= '0;
      else if (ras_hi_cnt < HW'(T_RP))       ras_hi_cnt <= ras_hi_cnt + 1'b1;
   end

   AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (ras_hi_cnt >= HW'(T_RP)));  // R4
   AST_RFSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && rf_pend) |=> (st == ST_RAS && is_rf));  // R10
   AST_RFSH_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      is_rf && st != ST_IDLE |-> dram_cas_n);  // R9
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);  // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (dram_ras_n && dram_cas_n && !dram_dq_oe));  // R1
endmodule

// File: tb/dram_seq_ctrl_bench.sv
module dram_seq_ctrl_bench;
   localparam int CLK_P    = 10;
   localparam int RW       = 4;
   localparam int CW       = 4;
   localparam int DW       = 8;
   localparam int T_RP     = 2;
   localparam int T_RCD    = 2;
   localparam int T_CAS    = 2;
   localparam int T_RC     = 8;
   localparam int INTERVAL = 60;
   localparam int DMAX     = 16;
   localparam int NLOC     = 1 << (RW + CW);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_we = 1'b0, req_late = 1'b0;
   logic [RW+CW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DW-1:0] rd_data, dram_dq_out, dram_dq_in;
   logic [3:0] dram_a;
   logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

   always #(CLK_P / 2) clk = ~clk;

   dram_seq_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RP(T_RP), .T_RCD(T_RCD),
      .T_CAS(T_CAS), .T_RC(T_RC), .RFSH_INTERVAL(INTERVAL), .ROW_HIGH(1)) u_dram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_late(req_late), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural DRAM on the pins
   logic [DW-1:0] mem [0:NLOC-1];
   logic [RW-1:0] rowl = '0;
   logic [CW-1:0] coll = '0;
   always @(negedge dram_ras_n) rowl = dram_a[RW-1:0];
   always @(negedge dram_cas_n) coll = dram_a[CW-1:0];
   assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? mem[{rowl, coll}] : 8'hA5;

   // pin monitor
   bit prev_ras = 1, prev_cas = 1, cas_seen = 0, seen_fall = 0;
   int hi_len = 100, since_fall = 0, cas_lo = 0, rf_gap = 0, rf_count = 0, rd_count = 0;
   logic [RW-1:0] exp_rrow = '0;
   bit fall_oe, fall_we, seen_oe, seen_we, acc_done, got_rv;
   logic [DW-1:0] got_rd;

   always @(negedge clk) if (rst_n) begin
      since_fall++;
      rf_gap++;
      if (prev_ras && !dram_ras_n) begin
         chk(hi_len >= T_RP, "R4 precharge", hi_len, T_RP);
         if (seen_fall) chk(since_fall >= T_RC, "R4 row cycle", since_fall, T_RC);
         since_fall = 0; seen_fall = 1; hi_len = 0; cas_seen = 0;
      end
      if (prev_cas && !dram_cas_n) begin
         chk(!dram_ras_n, "R3 cas under ras", dram_ras_n, 0);
         chk(since_fall >= T_RCD, "R3 ras-to-cas", since_fall, T_RCD);
         fall_oe = dram_oe_n; fall_we = dram_we_n; cas_seen = 1; cas_lo = 0;
      end
      if (!prev_cas && dram_cas_n) chk(cas_lo >= T_CAS, "R3 cas width", cas_lo, T_CAS);
      if (!dram_cas_n) begin
         cas_lo++;
         if (!dram_oe_n) seen_oe = 1;
         if (!dram_we_n) seen_we = 1;
         if (!dram_we_n && dram_dq_oe) mem[{rowl, coll}] = dram_dq_out;
      end
      if (dram_dq_oe) chk(!dram_ras_n && dram_oe_n, "R11 drive enable", dram_oe_n, 1);
      if (rd_valid) rd_count++;
      if (!prev_ras && dram_ras_n) begin
         if (!cas_seen) begin
            chk(rowl == exp_rrow, "R9 refresh row", rowl, exp_rrow);
            chk(rf_gap <= INTERVAL + DMAX, "R10 refresh gap", rf_gap, INTERVAL + DMAX);
            exp_rrow = exp_rrow + 1'b1; rf_gap = 0; rf_count++;
         end else begin
            acc_done = 1; got_rv = rd_valid; got_rd = rd_data;
         end
      end
      if (dram_ras_n) hi_len++;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
   end

   task automatic access(input bit wr, input bit late, input logic [7:0] adr,
                         input logic [7:0] wd);
      @(negedge clk);
      req_valid = 1; req_we = wr; req_late = late; req_addr = adr; req_wdata = wd;
      for (int i = 0; i < 40 && !req_ready; i++) @(negedge clk);
      acc_done = 0; fall_oe = 1; fall_we = 1; seen_oe = 0; seen_we = 0;
      @(negedge clk);
      req_valid = 0;
      for (int i = 0; i < 40 && !acc_done; i++) @(negedge clk);
      chk(acc_done, "R3 access completes", acc_done, 1);
      if (wr) begin
         chk(mem[adr] == wd, "R5 R2 written word", mem[adr], wd);
         chk(!got_rv, "R6 no valid on write", got_rv, 0);
         if (!late) chk(fall_we == 0, "R7 early write", fall_we, 0);
         else chk(fall_we == 1 && seen_we, "R8 late write", fall_we, 1);
      end else begin
         chk(got_rv && got_rd == wd, "R6 R2 read data", got_rd, wd);
         if (!late) chk(fall_oe == 0, "R7 early read", fall_oe, 0);
         else chk(fall_oe == 1 && seen_oe, "R8 late read", fall_oe, 1);
      end
   endtask

   function automatic logic [7:0] pat(input int a, input int p);
      return 8'((a * 37 + p * 91 + 5) & 8'hFF);
   endfunction

   initial begin
      for (int i = 0; i < NLOC; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset", 0, 1);
      chk(!dram_dq_oe && !rd_valid, "R1 quiet in reset", dram_dq_oe, 0);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk(dram_a == 0 && dram_ras_n, "R1 idle bus", dram_a, 0);
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < NLOC; a++) access(1, p[0], 8'(a), pat(a, p));
         for (int a = 0; a < NLOC; a++) access(0, !p[0], 8'(a), pat(a, p));
      end
      repeat (2 * INTERVAL) @(negedge clk);
      chk(rd_count == 2 * NLOC, "R6 read pulse count", rd_count, 2 * NLOC);
      chk(rf_count >= 20, "R10 refreshes served", rf_count, 20);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         chk(0, "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule